// File: doc/BRIEF.md
# SPI Slave Register-Access Port

This block is the serial front end of a small register file. An external SPI master selects it with chip enable, sends one command byte that names a register and a direction, and then moves any number of data bytes into or out of consecutive registers until chip enable is released. All serial pins are brought into the system clock domain and handled there. The core side is a plain register port: an address, a write strobe with data, and a fetch strobe with combinational read data.

The block needs no mode setting. When chip enable goes active, it takes the level of the serial clock at that moment as the idle level for the whole transaction. Data always moves on the second-edge phase: the master and the slave launch bits on the edge that leaves the idle level and capture them on the edge that returns to it. Both idle levels therefore work, which are SPI modes 1 and 3. The system clock must run at least four times faster than the serial clock.

Top module: `spi_regport`

## Requirements
- R1: The serial clock idle level seen when chip enable becomes active is held as the polarity for that transaction. Low idle (mode 1) and high idle (mode 3) both transfer correctly.
- R2: The first byte after chip enable is a command, most significant bit first. Bit 7 set means write and bit 7 clear means read. Bits 6:0 give the starting register address.
- R3: In a write transaction, each completed data byte produces a `reg_wr_o` pulse lasting exactly one system clock. The pulse carries that byte on `reg_wdata_o` and the current address on `reg_addr_o`.
- R4: Consecutive data bytes in one transaction go to consecutive addresses. The address steps by one after each byte and wraps from 127 to 0.
- R5: In a read transaction, `miso_o` carries the addressed register most significant bit first. The first bit is launched on the first leading serial clock edge after the command byte, so the master can sample each bit on the trailing edge.
- R6: In read mode, every completed byte (the command byte and each data byte) is followed by one `reg_rd_o` fetch pulse for the next address. A burst of N data bytes therefore issues N+1 fetches. A fetch never coincides with a write strobe.
- R7: A byte that chip enable cuts short is discarded. It produces no register write.
- R8: After chip enable is released, the next transaction treats its first byte as a new command.
- R9: `miso_oe_o` is low while chip enable is inactive and throughout a write transaction. It is high during the data phase of a read.
- R10: After reset, `miso_oe_o`, `reg_wr_o` and `reg_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable from the master, active high |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the serial data pin |
| reg_addr_o | output | 7 | Register address |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_o | output | 1 | Register fetch strobe |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o`, combinational |

## Verification
A polarity latched at the wrong level swaps launch and capture. The effect shows within the first command byte: a wrong address, a wrong direction, or no write strobe at all. A bit counter that is off by one, or that is not cleared when chip enable drops, moves every later byte by one bit. The bench sees this in the next register write or in the next byte read back on `miso_o`. A wrong address step shows only on the second byte of a burst, so the bench runs bursts that cross the 127-to-0 wrap. A late register fetch shows on the first read bit as the previous byte's value.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  // Transaction phase after chip enable goes active
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_regport_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous inputs.
module spi_regport_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;

    always_comb begin
      chain_n = {chain_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_n;
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_regport_edge.sv
// Chip-enable framing, polarity capture and serial clock edge classification.
module spi_regport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s,
  input  logic sclk_s,
  output logic active_o,
  output logic pol_o,
  output logic launch_o,
  output logic capture_o
);
  logic ce_d, sclk_d, pol_q;
  logic pol_n, ce_rise;

  assign ce_rise  = ce_s & ~ce_d;
  assign active_o = ce_s & ce_d;

  always_comb begin
    pol_n = pol_q;
    if (ce_rise) pol_n = sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d   <= 1'b0;
      sclk_d <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      ce_d   <= ce_s;
      sclk_d <= sclk_s;
      pol_q  <= pol_n;
    end
  end

  // Leading edge leaves the idle level; trailing edge returns to it.
  assign launch_o  = active_o & (sclk_d == pol_q) & (sclk_s != pol_q);
  assign capture_o = active_o & (sclk_d != pol_q) & (sclk_s == pol_q);
  assign pol_o     = pol_q;
endmodule

// File: rtl/spi_regport_shift.sv
// Receive shifter with bit counter, and transmit shifter for MISO.
module spi_regport_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         capture_i,
  input  logic         launch_i,
  input  logic         mosi_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         byte_done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         miso_o
);
  localparam int CNT_W = $clog2(W);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W-1:0]     rx_q, rx_n;
  logic [W-1:0]     tx_q, tx_n;
  logic             miso_q, miso_n;
  logic             last_bit;

  assign last_bit    = (cnt_q == CNT_W'(W - 1));
  assign byte_done_o = capture_i & last_bit & ~clear_i;
  assign rx_byte_o   = {rx_q[W-2:0], mosi_i};

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    if (clear_i) begin
      cnt_n = '0;
    end else if (capture_i) begin
      rx_n  = {rx_q[W-2:0], mosi_i};
      cnt_n = last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    tx_n   = tx_q;
    miso_n = miso_q;
    if (load_i) begin
      tx_n = load_data_i;
    end else if (launch_i) begin
      miso_n = tx_q[W-1];
      tx_n   = {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      miso_q <= miso_n;
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/spi_regport_ctrl.sv
// Command decode, burst addressing and register-port strobes.
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           byte_done_i,
  input  logic [W-1:0]   rx_byte_i,
  output logic [W-2:0]   addr_o,
  output logic           wr_o,
  output logic [W-1:0]   wdata_o,
  output logic           rd_o,
  output logic           load_o,
  output logic           oe_o
);
  localparam int AW      = W - 1;
  localparam int DIR_BIT = W - 1;

  phase_e        phase_q, phase_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [W-1:0]  wdata_q, wdata_n;
  logic          wr_q, wr_n;
  logic          rd_q, rd_n;

  always_comb begin
    phase_n = phase_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    // Step past a register once its write strobe has been issued.
    if (wr_q) addr_n = addr_q + 1'b1;
    if (clear_i) begin
      phase_n = PH_CMD;
    end else if (byte_done_i) begin
      unique case (phase_q)
        PH_CMD: begin
          addr_n = rx_byte_i[AW-1:0];
          if (rx_byte_i[DIR_BIT]) begin
            phase_n = PH_WRITE;
          end else begin
            phase_n = PH_READ;
            rd_n    = 1'b1;
          end
        end
        PH_WRITE: begin
          wr_n    = 1'b1;
          wdata_n = rx_byte_i;
        end
        PH_READ: begin
          addr_n = addr_q + 1'b1;
          rd_n   = 1'b1;
        end
        default: phase_n = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
    end
  end

  assign addr_o  = addr_q;
  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;
  assign rd_o    = rd_q;
  // Read data is valid while the fetch strobe is high; take it at that edge.
  assign load_o  = rd_q;
  assign oe_o    = (phase_q == PH_READ) & ~clear_i;
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-2:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int ADDR_W = DATA_W - 1;

  logic [2:0]        pins_s;
  logic              ce_s, sclk_s, mosi_s;
  logic              active, pol, launch, capture, clear;
  logic              byte_done, load;
  logic [DATA_W-1:0] rx_byte;

  spi_regport_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ce_i, sclk_i, mosi_i}),
    .sync_o  (pins_s)
  );

  assign {ce_s, sclk_s, mosi_s} = pins_s;

  spi_regport_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (ce_s),
    .sclk_s    (sclk_s),
    .active_o  (active),
    .pol_o     (pol),
    .launch_o  (launch),
    .capture_o (capture)
  );

  assign clear = ~active;

  spi_regport_shift #(.W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .capture_i   (capture),
    .launch_i    (launch),
    .mosi_i      (mosi_s),
    .load_i      (load),
    .load_data_i (reg_rdata_i),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .miso_o      (miso_o)
  );

  spi_regport_ctrl #(.W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .addr_o      (reg_addr_o),
    .wr_o        (reg_wr_o),
    .wdata_o     (reg_wdata_o),
    .rd_o        (reg_rd_o),
    .load_o      (load),
    .oe_o        (miso_oe_o)
  );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              active,
  input logic              pol,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic              miso_oe_o,
  input logic [ADDR_W-1:0] reg_addr_o
);
  // R1: polarity held for the whole transaction
  assert_pol_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(pol));

  // R3: write strobe lasts one clock
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  // R4: address advances by one after each write
  assert_wr_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1));

  // R6: fetch and write never together
  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  // R9: no drive while deselected
  assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |-> !miso_oe_o);

  // R9: no drive while writing
  assert_oe_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> !miso_oe_o);
endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_s       (ce_s),
  .active     (active),
  .pol        (pol),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .miso_oe_o  (miso_oe_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/sim_spi_regport.sv
`timescale 1ns/1ps
module sim_spi_regport;
  localparam int H = 6; // system clocks per half serial clock period

  logic       clk, rst_n, ce, sclk, mosi;
  logic       miso, miso_oe, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem     [0:127];
  logic [7:0] exp_mem [0:127];
  logic [7:0] tx_buf  [0:3];
  logic [7:0] rx_buf  [0:3];
  int checks, errors, wr_cnt, rd_cnt;
  logic oe_seen;

  spi_regport u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_addr_o(reg_addr),
    .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    if (miso_oe) oe_seen <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Full-duplex transfer of nbits from tx_buf, MSB first, second-edge phase.
  task automatic xfer(input logic pol, input int nbits);
    @(negedge clk);
    sclk = pol;
    repeat (H) @(negedge clk);
    ce = 1'b1;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      sclk = ~pol;
      mosi = tx_buf[b / 8][7 - (b % 8)];
      repeat (H) @(negedge clk);
      rx_buf[b / 8][7 - (b % 8)] = miso;
      sclk = pol;
      repeat (H) @(negedge clk);
    end
    repeat (H) @(negedge clk);
    ce = 1'b0;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 oe", miso_oe, 0);
    chk("R10 wr", reg_wr, 0);
    chk("R10 rd", reg_rd, 0);
  endtask

  task automatic t_write_single_mode3();
    int w0 = wr_cnt;
    oe_seen = 1'b0;
    tx_buf[0] = 8'h85; tx_buf[1] = 8'hA5;
    exp_mem[5] = 8'hA5;
    xfer(1'b1, 16);
    chk("R1 R2 R3 mode3 write data", mem[5], exp_mem[5]);
    chk("R3 one strobe", wr_cnt - w0, 1);
    chk("R2 neighbour untouched", mem[6], exp_mem[6]);
    chk("R9 oe low in write", oe_seen, 0);
  endtask

  task automatic t_write_burst_wrap();
    int w0 = wr_cnt;
    tx_buf[0] = 8'h80 | 8'd126;
    tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
    exp_mem[126] = 8'h11; exp_mem[127] = 8'h22; exp_mem[0] = 8'h33;
    xfer(1'b0, 32);
    chk("R4 addr 126", mem[126], exp_mem[126]);
    chk("R4 addr 127", mem[127], exp_mem[127]);
    chk("R4 wrap to 0", mem[0], exp_mem[0]);
    chk("R3 R4 strobe count", wr_cnt - w0, 3);
  endtask

  task automatic t_read_burst_mode1();
    int r0 = rd_cnt;
    oe_seen = 1'b0;
    tx_buf[0] = 8'd126;
    tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    xfer(1'b0, 32);
    chk("R5 R6 read 126", rx_buf[1], exp_mem[126]);
    chk("R6 read 127", rx_buf[2], exp_mem[127]);
    chk("R6 read wrap 0", rx_buf[3], exp_mem[0]);
    chk("R6 fetch count", rd_cnt - r0, 4);
    chk("R9 oe high in read", oe_seen, 1);
    chk("R9 oe low after CE", miso_oe, 0);
  endtask

  task automatic t_read_mode3();
    tx_buf[0] = 8'h05; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    xfer(1'b1, 24);
    chk("R1 R5 mode3 read 5", rx_buf[1], exp_mem[5]);
    chk("R5 mode3 read 6", rx_buf[2], exp_mem[6]);
  endtask

  task automatic t_partial_then_fresh();
    int w0 = wr_cnt;
    tx_buf[0] = 8'h80 | 8'd40; tx_buf[1] = 8'hF0;
    xfer(1'b0, 13);
    chk("R7 no strobe on partial", wr_cnt - w0, 0);
    chk("R7 reg unchanged", mem[40], exp_mem[40]);
    tx_buf[0] = 8'h80 | 8'd40; tx_buf[1] = 8'h5A;
    exp_mem[40] = 8'h5A;
    xfer(1'b1, 16);
    chk("R8 fresh command write", mem[40], exp_mem[40]);
    chk("R8 one strobe", wr_cnt - w0, 1);
    tx_buf[0] = 8'd40; tx_buf[1] = 8'h00;
    xfer(1'b0, 16);
    chk("R8 read back", rx_buf[1], exp_mem[40]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; wr_cnt = 0; rd_cnt = 0; oe_seen = 1'b0;
    for (int i = 0; i < 128; i++) begin
      mem[i]     = 8'((i * 37 + 11) ^ 8'h5C);
      exp_mem[i] = 8'((i * 37 + 11) ^ 8'h5C);
    end
    ce = 1'b0; sclk = 1'b0; mosi = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_single_mode3();
    t_write_burst_wrap();
    t_read_burst_mode1();
    t_read_mode3();
    t_partial_then_fresh();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule